// File: doc/BRIEF.md
# Per-Channel Attenuating Stereo Mixer

This block combines up to four independent 16-bit stereo sample streams into one stereo stream for a converter. Typical sources are host playback data, two serial audio inputs and an internal synthesizer. Each stream is written into the block with its own strobe. The block keeps the most recent left/right pair of each stream until a newer pair replaces it.

When the consumer pulses an output request, the block works on every stream's held pair. It scales the pair by that channel's logarithmic attenuation code, in 1.5 dB steps from 0 dB down to -94.5 dB, or forces it to zero if the channel is muted. It then adds the four contributions in a wide accumulator and clamps the result to the 16-bit range. The mixed pair is registered and flagged valid one cycle after the request.

Attenuation is split into two parts. The two low bits of the code choose one of four fractional gains. The upper bits choose an arithmetic right shift of one bit for every 6 dB.

Top module: `stream_atten_mixer`

## Requirements
- R1: After reset `mix_valid` is 0, both mix outputs are 0, and every held sample is 0, so a request issued before any sample has arrived yields 0 on both sides.
- R2: A high `smp_stb[i]` in a cycle stores that cycle's left and right lanes of channel i, where channel i occupies bits [16*i+15:16*i] of `smp_left`/`smp_right`. The stored pair is used by every later request until channel i is strobed again.
- R3: A sample strobed in the same cycle as a request is not part of that request's result. It is used from the next request on.
- R4: With `ch_mute[i]` = 1, channel i contributes exactly zero on both sides, whatever its attenuation code. With all four muted the output is 0.
- R5: A channel with code c (bits [6*i+5:6*i] of `ch_atten`) and held sample s contributes floor(s * G[c mod 4] / 2^(14 + c div 4)), with G = {16384, 13785, 11599, 9759}. Code 0 passes s unchanged, and code 63 reduces any sample to 0 or -1.
- R6: `mix_valid` is high for exactly the one cycle after each cycle with `mix_req` high. It is low otherwise. The mix outputs keep their last value in cycles after which no request was made.
- R7: The sum of the four contributions is clamped to 32767 when above it and to -32768 when below -32768.
- R8: Left and right are processed independently, using the same code and mute for a channel on both sides.
- R9: Codes and mute bits are taken in the request cycle. A change made after that cycle does not alter that request's result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_stb | input | 4 | Per-channel sample strobe |
| smp_left | input | 64 | Left samples, 16 bits per channel, twos complement |
| smp_right | input | 64 | Right samples, 16 bits per channel, twos complement |
| ch_atten | input | 24 | Attenuation code, 6 bits per channel, 1.5 dB per step |
| ch_mute | input | 4 | Per-channel mute |
| mix_req | input | 1 | Output request strobe |
| mix_valid | output | 1 | Result valid, one cycle after the request |
| mix_left | output | 16 | Mixed, saturated left sample |
| mix_right | output | 16 | Mixed, saturated right sample |

## Verification
A held sample that is stale or lost shows up as a wrong value in the very next result pair, one cycle after the request that reads it. A wrong gain index or shift count produces a result that differs from the fractional-gain model on the first request using that code. The bench therefore steps one channel through consecutive codes, including the deepest one. A missing clamp shows up as a sign flip on the first request whose sum leaves the 16-bit range. A fault in the request-to-valid path shows up as an unexpected, missing or repeated valid flag within one cycle.

// File: rtl/mixer_pkg.sv
package mixer_pkg;
  localparam int GAIN_FRAC = 14;

  // fractional gains for 0, -1.5, -3 and -4.5 dB with GAIN_FRAC fraction bits
  function automatic logic [15:0] sub_step_gain(input logic [1:0] idx);
    case (idx)
      2'd0:    return 16'd16384;
      2'd1:    return 16'd13785;
      2'd2:    return 16'd11599;
      default: return 16'd9759;
    endcase
  endfunction
endpackage

// File: rtl/atten_stage.sv
module atten_stage #(
  parameter int DW = 16,
  parameter int CW = 6
) (
  input  logic signed [DW-1:0] smp,
  input  logic [CW-1:0]        code,
  input  logic                 mute,
  output logic signed [DW-1:0] scaled
);
  import mixer_pkg::*;

  localparam int PW = DW + 17;

  logic signed [16:0]   gain;
  logic signed [PW-1:0] prod;
  logic [7:0]           shamt;

  always_comb begin
    gain   = $signed({1'b0, sub_step_gain(code[1:0])});
    prod   = PW'(smp) * PW'(gain);
    shamt  = 8'(GAIN_FRAC) + 8'(code[CW-1:2]);
    scaled = mute ? '0 : DW'(prod >>> shamt);
  end
endmodule

// File: rtl/sat_sum.sv
module sat_sum #(
  parameter int NCH = 4,
  parameter int DW  = 16
) (
  input  logic [NCH*DW-1:0]    terms,
  output logic signed [DW-1:0] total
);
  localparam int ACCW = DW + $clog2(NCH) + 1;
  localparam logic signed [ACCW-1:0] HI = ACCW'((1 << (DW-1)) - 1);
  localparam logic signed [ACCW-1:0] LO = -ACCW'(1 << (DW-1));

  logic signed [ACCW-1:0] acc;

  always_comb begin
    acc = '0;
    for (int i = 0; i < NCH; i++)
      acc = acc + ACCW'($signed(terms[i*DW +: DW]));
    if (acc > HI)      total = HI[DW-1:0];
    else if (acc < LO) total = LO[DW-1:0];
    else               total = acc[DW-1:0];
  end
endmodule

// File: rtl/stream_atten_mixer.sv
module stream_atten_mixer #(
  parameter int NCH = 4,
  parameter int DW  = 16,
  parameter int CW  = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NCH-1:0]    smp_stb,
  input  logic [NCH*DW-1:0] smp_left,
  input  logic [NCH*DW-1:0] smp_right,
  input  logic [NCH*CW-1:0] ch_atten,
  input  logic [NCH-1:0]    ch_mute,
  input  logic              mix_req,
  output logic              mix_valid,
  output logic [DW-1:0]     mix_left,
  output logic [DW-1:0]     mix_right
);
  logic [NCH*DW-1:0] held_l, held_r;
  logic [NCH*DW-1:0] term_l, term_r;
  logic signed [DW-1:0] sum_l, sum_r;

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    always_ff @(posedge clk) begin
      if (rst) begin
        held_l[ch*DW +: DW] <= '0;
        held_r[ch*DW +: DW] <= '0;
      end else if (smp_stb[ch]) begin
        held_l[ch*DW +: DW] <= smp_left[ch*DW +: DW];
        held_r[ch*DW +: DW] <= smp_right[ch*DW +: DW];
      end
    end

    atten_stage #(.DW(DW), .CW(CW)) u_att_l (
      .smp(held_l[ch*DW +: DW]), .code(ch_atten[ch*CW +: CW]),
      .mute(ch_mute[ch]), .scaled(term_l[ch*DW +: DW]));
    atten_stage #(.DW(DW), .CW(CW)) u_att_r (
      .smp(held_r[ch*DW +: DW]), .code(ch_atten[ch*CW +: CW]),
      .mute(ch_mute[ch]), .scaled(term_r[ch*DW +: DW]));
  end

  sat_sum #(.NCH(NCH), .DW(DW)) u_sum_l (.terms(term_l), .total(sum_l));
  sat_sum #(.NCH(NCH), .DW(DW)) u_sum_r (.terms(term_r), .total(sum_r));

  always_ff @(posedge clk) begin
    if (rst) begin
      mix_valid <= 1'b0;
      mix_left  <= '0;
      mix_right <= '0;
    end else begin
      mix_valid <= mix_req;
      if (mix_req) begin
        mix_left  <= sum_l;
        mix_right <= sum_r;
      end
    end
  end
endmodule

// File: rtl/mixer_checker.sv
module mixer_checker #(
  parameter int NCH = 4,
  parameter int DW  = 16
) (
  input logic           clk,
  input logic           rst,
  input logic           mix_req,
  input logic [NCH-1:0] ch_mute,
  input logic           mix_valid,
  input logic [DW-1:0]  mix_left,
  input logic [DW-1:0]  mix_right
);
  // R6: a request is answered in the following cycle
  p_valid_follows_req_r6: assert property (@(posedge clk) disable iff (rst)
    mix_req |=> mix_valid);

  // R6: no valid flag without a request
  p_no_spurious_valid_r6: assert property (@(posedge clk) disable iff (rst)
    !mix_req |=> !mix_valid);

  // R6: outputs hold between requests
  p_hold_output_r6: assert property (@(posedge clk) disable iff (rst)
    !mix_req |=> ($stable(mix_left) && $stable(mix_right)));

  // R4: all channels muted gives silence
  p_all_muted_silent_r4: assert property (@(posedge clk) disable iff (rst)
    (mix_req && (&ch_mute)) |=> (mix_left == '0 && mix_right == '0));
endmodule

bind stream_atten_mixer mixer_checker #(.NCH(NCH), .DW(DW)) u_chk (
  .clk(clk), .rst(rst), .mix_req(mix_req), .ch_mute(ch_mute),
  .mix_valid(mix_valid), .mix_left(mix_left), .mix_right(mix_right));

// File: tb/stream_atten_mixer_test.sv
`timescale 1ns/1ps
module stream_atten_mixer_test;
  localparam int NCH = 4, DW = 16, CW = 6;

  logic clk = 1'b0, rst = 1'b1;
  logic [NCH-1:0] smp_stb = '0;
  logic [NCH*DW-1:0] smp_left = '0, smp_right = '0;
  logic [NCH*CW-1:0] ch_atten = '0;
  logic [NCH-1:0] ch_mute = '0;
  logic mix_req = 1'b0;
  logic mix_valid;
  logic [DW-1:0] mix_left, mix_right;

  stream_atten_mixer #(.NCH(NCH), .DW(DW), .CW(CW)) uut (.*);

  always #2 clk = ~clk;

  int checks = 0, errors = 0;
  int m_l[NCH], m_r[NCH];
  int q_l[$], q_r[$];
  string q_tag[$];
  int last_l = 0, last_r = 0;
  bit mon_on = 0;

  function automatic int scale(int s, int c);
    longint g, p;
    case (c % 4)
      0: g = 16384; 1: g = 13785; 2: g = 11599; default: g = 9759;
    endcase
    p = longint'(s) * g;
    return int'(p >>> (14 + c / 4));
  endfunction

  function automatic int model_mix(bit left);
    int acc = 0;
    for (int ch = 0; ch < NCH; ch++)
      if (!ch_mute[ch])
        acc += scale(left ? m_l[ch] : m_r[ch], int'(ch_atten[ch*CW +: CW]));
    if (acc > 32767) acc = 32767;
    if (acc < -32768) acc = -32768;
    return acc;
  endfunction

  function automatic int s16(logic [15:0] v);
    return int'($signed(v));
  endfunction

  task automatic check(bit ok, string tag, int al, int ar, int el, int er);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got L=%0d R=%0d expected L=%0d R=%0d", tag, al, ar, el, er);
    end
  endtask

  task automatic set_cfg(int ch, int code, bit mu);
    @(negedge clk);
    ch_atten[ch*CW +: CW] = CW'(code);
    ch_mute[ch] = mu;
  endtask

  task automatic put_sample(int ch, int l, int r);
    @(negedge clk);
    smp_stb[ch] = 1'b1;
    smp_left[ch*DW +: DW] = DW'(l);
    smp_right[ch*DW +: DW] = DW'(r);
    @(posedge clk);
    #1 smp_stb = '0;
    m_l[ch] = l; m_r[ch] = r;
  endtask

  task automatic request(string tag);
    @(negedge clk);
    q_l.push_back(model_mix(1)); q_r.push_back(model_mix(0)); q_tag.push_back(tag);
    mix_req = 1'b1;
    @(posedge clk);
    #1 mix_req = 1'b0;
  endtask

  task automatic request_with_sample(int ch, int l, int r, string tag);
    @(negedge clk);
    q_l.push_back(model_mix(1)); q_r.push_back(model_mix(0)); q_tag.push_back(tag);
    mix_req = 1'b1;
    smp_stb[ch] = 1'b1;
    smp_left[ch*DW +: DW] = DW'(l);
    smp_right[ch*DW +: DW] = DW'(r);
    @(posedge clk);
    #1 begin mix_req = 1'b0; smp_stb = '0; end
    m_l[ch] = l; m_r[ch] = r;
  endtask

  // monitor: pops expected results as they appear
  always @(negedge clk) begin
    if (mon_on && !rst) begin
      if (mix_valid) begin
        if (q_l.size() == 0) begin
          check(0, "R6 unexpected valid", s16(mix_left), s16(mix_right), 0, 0);
        end else begin
          int el, er; string t;
          el = q_l.pop_front(); er = q_r.pop_front(); t = q_tag.pop_front();
          check(s16(mix_left) == el && s16(mix_right) == er, t,
                s16(mix_left), s16(mix_right), el, er);
        end
        last_l = s16(mix_left); last_r = s16(mix_right);
      end else begin
        check(s16(mix_left) == last_l && s16(mix_right) == last_r, "R6 hold",
              s16(mix_left), s16(mix_right), last_l, last_r);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got L=0 R=0 expected L=0 R=0");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int ch = 0; ch < NCH; ch++) begin m_l[ch] = 0; m_r[ch] = 0; end
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    check(mix_valid == 0 && mix_left == 0 && mix_right == 0, "R1 reset state",
          s16(mix_left), s16(mix_right), 0, 0);
    mon_on = 1;
    // R1: held values are zero before any sample arrives
    request("R1 empty request");

    // R2: single channel, unity gain
    put_sample(0, 1000, -2000);
    request("R2 channel 0 unity");

    // R5: step through sub-steps and shifts on one channel
    put_sample(0, 16000, -16000);
    for (int c = 1; c <= 9; c++) begin
      set_cfg(0, c, 0);
      request("R5 code step");
    end
    put_sample(0, -32768, 32767);
    set_cfg(0, 63, 0);
    request("R5 deepest code");

    // R2 R8: four channels, different codes and sides
    set_cfg(0, 0, 0); set_cfg(1, 3, 0); set_cfg(2, 8, 0); set_cfg(3, 17, 0);
    put_sample(0, 1234, -321);
    put_sample(1, -5000, 7000);
    put_sample(2, 20000, 100);
    put_sample(3, -30000, 30001);
    request("R8 four-channel mix");
    put_sample(2, -7, 9);
    request("R2 one channel replaced");

    // R7: saturation on both rails
    for (int ch = 0; ch < NCH; ch++) set_cfg(ch, 0, 0);
    for (int ch = 0; ch < NCH; ch++) put_sample(ch, 30000, -30000);
    request("R7 clamp");

    // R4: mute one, then all
    set_cfg(1, 0, 1);
    request("R4 one muted");
    for (int ch = 0; ch < NCH; ch++) set_cfg(ch, 0, 1);
    request("R4 all muted");
    for (int ch = 0; ch < NCH; ch++) set_cfg(ch, 0, 0);

    // R3: sample arriving with the request counts only later
    request_with_sample(2, -12345, 4321, "R3 same-cycle sample excluded");
    request("R3 sample used next");

    // R9: change code right after the request
    set_cfg(3, 2, 0);
    request("R9 config at request");
    set_cfg(3, 40, 0);
    request("R9 new config");

    // R6: back-to-back requests
    request("R6 back-to-back a");
    request("R6 back-to-back b");

    repeat (4) @(negedge clk);
    check(q_l.size() == 0, "R6 outstanding results", q_l.size(), 0, 0, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule